// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software through a down counter that has to be serviced before it runs out. When it first expires it raises an interrupt and starts counting again from the load value. If it expires a second time while that interrupt is still pending, and reset generation is enabled, it asserts a system reset request. The request stays high until the block itself is reset.

Software reaches the block through a plain single-cycle register port. One write strobe carries a word address and write data. Read data is combinational from the address. Software sets the reload value, starts the timer, and chooses whether the second expiry resets the system. It services the timer by writing the clear register, which also restarts the count. A lock register, opened only by a fixed key, write-protects the configuration and the clear register against stray writes.

Register map (word address on `reg_addr`): 0 reload value (read/write), 1 current count (read-only), 2 control (bit 0 run, bit 1 reset enable), 3 clear (write-only, reads 0), 4 raw status (bit 0), 5 masked status (bit 0), 6 lock (reads 1 when locked), 7 unused (reads 0).

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the reload value and the count are all ones. Control, raw status, masked status and lock all read 0. `irq` and `sys_rst_req` are low.
- R2: While the run bit is 0, the count holds. While it is 1, the count drops by one on each clock in which it is non-zero and no reload-value or clear write takes effect.
- R3: When the count is 0 on a clock edge while running, the count is reloaded from the reload value and the raw status bit (address 4, bit 0) is set.
- R4: An expiry while the raw status is already set and reset enable (address 2, bit 1) is 1 sets `sys_rst_req` on that edge. It then stays high until `rst_n` is asserted.
- R5: An expiry while the raw status is set and reset enable is 0 only reloads the count. The raw status stays set and `sys_rst_req` stays low.
- R6: Any write to address 3, when unlocked, clears the raw status and reloads the count from the reload value. It takes precedence over an expiry in the same cycle.
- R7: A write to address 0, when unlocked, sets both the reload value and the count to the written data in the same cycle. It takes precedence over counting and expiry.
- R8: Control bit 0 (run) can be set but not cleared by a write. Control bit 1 follows the written value.
- R9: Writing 0x1ACCE551 to address 6 unlocks. Writing any other value locks. The lock register reads 1 when locked and 0 when unlocked, and it is always writable.
- R10: While locked, writes to addresses 0, 2 and 3 have no effect.
- R11: The masked status (address 5, bit 0) and `irq` equal the raw status ANDed with the run bit. The run bit also acts as the interrupt enable.
- R12: Writes to addresses 1, 4, 5 and 7 have no effect. Address 1 reads the live count. Addresses 3 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr` |
| irq | output | 1 | Timeout interrupt |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
Directed sequences use small reload values, so the exact expiry cycles can be predicted. They separate a first expiry (interrupt only) from a second expiry with reset enabled (reset request) and from one with reset disabled (reload only). They also test service by a clear write just before expiry, and a reload-value write while counting, which restarts the count at once. Lock sequences write the key and a wrong value, so that protected and unprotected writes can be told apart. A long stretch of seeded random writes, reads and lock toggles then drives frequent expiries against a cycle-level reference model. This exposes ordering errors among reload write, clear, expiry and decrement within one cycle.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int DW = 32,
  parameter logic [DW-1:0] UNLOCK_KEY = DW'(32'h1ACC_E551)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          sys_rst_req
);
  localparam logic [2:0] A_LOAD = 3'd0, A_CNT = 3'd1, A_CTRL = 3'd2, A_CLR = 3'd3,
                         A_RAW = 3'd4, A_MIS = 3'd5, A_LOCK = 3'd6;

  logic [DW-1:0] load_q, count_q;
  logic en_q, rsten_q, raw_q, lock_q;
  logic wr_load, wr_ctrl, wr_clr, wr_lock, expire, masked;

  assign wr_lock = reg_we && reg_addr == A_LOCK;
  assign wr_load = reg_we && !lock_q && reg_addr == A_LOAD;
  assign wr_ctrl = reg_we && !lock_q && reg_addr == A_CTRL;
  assign wr_clr  = reg_we && !lock_q && reg_addr == A_CLR;
  assign expire  = en_q && count_q == '0;
  assign masked  = raw_q && en_q;
  assign irq     = masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q      <= '1;
      count_q     <= '1;
      en_q        <= 1'b0;
      rsten_q     <= 1'b0;
      raw_q       <= 1'b0;
      lock_q      <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      if (wr_lock) lock_q <= reg_wdata != UNLOCK_KEY;
      if (wr_ctrl) begin
        en_q    <= en_q | reg_wdata[0];
        rsten_q <= reg_wdata[1];
      end
      if (wr_load) begin
        load_q  <= reg_wdata;
        count_q <= reg_wdata;
      end else if (wr_clr) begin
        raw_q   <= 1'b0;
        count_q <= load_q;
      end else if (expire) begin
        count_q <= load_q;
        raw_q   <= 1'b1;
        if (raw_q && rsten_q) sys_rst_req <= 1'b1;
      end else if (en_q) begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_LOAD:  reg_rdata = load_q;
      A_CNT:   reg_rdata = count_q;
      A_CTRL:  reg_rdata = {{(DW-2){1'b0}}, rsten_q, en_q};
      A_RAW:   reg_rdata = {{(DW-1){1'b0}}, raw_q};
      A_MIS:   reg_rdata = {{(DW-1){1'b0}}, masked};
      A_LOCK:  reg_rdata = {{(DW-1){1'b0}}, lock_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic          sys_rst_req,
  input logic [DW-1:0] count_q,
  input logic [DW-1:0] load_q,
  input logic          en_q,
  input logic          rsten_q,
  input logic          raw_q,
  input logic          lock_q
);
  // R4
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);

  // R4
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(raw_q && rsten_q && en_q));

  // R8
  run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !reg_we) |=> $stable(count_q));

  // R2
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && count_q != '0 && !reg_we) |=> count_q == $past(count_q) - 1'b1);

  // R3
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && count_q == '0 && !reg_we) |=> (raw_q && count_q == $past(load_q)));

  // R11
  raw_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q |-> en_q);

  // R10
  locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && reg_we && reg_addr == 3'd0) |=> $stable(load_q));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .sys_rst_req(sys_rst_req), .count_q(count_q), .load_q(load_q),
  .en_q(en_q), .rsten_q(rsten_q), .raw_q(raw_q), .lock_q(lock_q)
);

// File: tb/wdog_two_stage_tb_top.sv
`timescale 1ns/1ps
module wdog_two_stage_tb_top;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, sys_rst_req;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_load, m_cnt;
  logic m_en, m_rsten, m_raw, m_lock, m_rst;

  always #4 clk = ~clk;

  wdog_two_stage dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sys_rst_req(sys_rst_req)
  );

  function automatic logic [31:0] mread(input logic [2:0] a);
    case (a)
      3'd0: return m_load;
      3'd1: return m_cnt;
      3'd2: return {30'd0, m_rsten, m_en};
      3'd4: return {31'd0, m_raw};
      3'd5: return {31'd0, m_raw & m_en};
      3'd6: return {31'd0, m_lock};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R7";
      3'd1: return "R2";
      3'd2: return "R8";
      3'd4: return "R3";
      3'd5: return "R11";
      3'd6: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_load = '1; m_cnt = '1; m_en = 0; m_rsten = 0; m_raw = 0; m_lock = 0; m_rst = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_we = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic model_step(input bit we, input logic [2:0] a, input logic [31:0] d);
    logic [31:0] n_load = m_load, n_cnt = m_cnt;
    logic n_en = m_en, n_rsten = m_rsten, n_raw = m_raw, n_lock = m_lock, n_rst = m_rst;
    bit open = !m_lock;
    if (we && a == 3'd6) n_lock = (d != KEY);
    if (we && a == 3'd2 && open) begin n_en = m_en | d[0]; n_rsten = d[1]; end
    if (we && a == 3'd0 && open) begin n_load = d; n_cnt = d; end
    else if (we && a == 3'd3 && open) begin n_raw = 0; n_cnt = m_load; end
    else if (m_en) begin
      if (m_cnt == 0) begin
        n_cnt = m_load; n_raw = 1;
        if (m_raw && m_rsten) n_rst = 1;
      end else n_cnt = m_cnt - 1;
    end
    m_load = n_load; m_cnt = n_cnt; m_en = n_en; m_rsten = n_rsten;
    m_raw = n_raw; m_lock = n_lock; m_rst = n_rst;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit we, input logic [2:0] a, input logic [31:0] d);
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_step(we, a, d);
    @(negedge clk);
    reg_we = 1'b0;
    check(irq === (m_raw & m_en), "R11", "irq", {31'd0, irq}, {31'd0, m_raw & m_en});
    check(sys_rst_req === m_rst, "R4", "sys_rst_req", {31'd0, sys_rst_req}, {31'd0, m_rst});
    check(reg_rdata === mread(a), req_of(a), "rdata", reg_rdata, mread(a));
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
    reg_we = 1'b0; reg_addr = a;
    #1;
    check(reg_rdata === exp, req, "read", reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd1, 32'd0);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd(3'd0, "R1", 32'hFFFF_FFFF);
    rd(3'd1, "R1", 32'hFFFF_FFFF);
    rd(3'd2, "R1", 32'd0);
    rd(3'd4, "R1", 32'd0);
    rd(3'd6, "R1", 32'd0);
    check(!irq && !sys_rst_req, "R1", "outputs", {30'd0, irq, sys_rst_req}, 32'd0);

    // R2 hold while stopped, R7 load
    cyc(1'b1, 3'd0, 32'd5);
    idle(3);
    rd(3'd1, "R2", 32'd5);
    // start with reset enable; 5 decrements then expiry
    cyc(1'b1, 3'd2, 32'd3);
    idle(5);
    rd(3'd1, "R2", 32'd0);
    check(irq === 1'b0, "R3", "irq before expiry", {31'd0, irq}, 32'd0);
    idle(1);
    check(irq === 1'b1, "R3", "irq after first expiry", {31'd0, irq}, 32'd1);
    rd(3'd1, "R3", 32'd5);
    rd(3'd4, "R3", 32'd1);
    idle(5);
    check(sys_rst_req === 1'b0, "R4", "no reset before second expiry", {31'd0, sys_rst_req}, 32'd0);
    idle(1);
    check(sys_rst_req === 1'b1, "R4", "reset on second expiry", {31'd0, sys_rst_req}, 32'd1);
    cyc(1'b1, 3'd3, 32'd0);
    idle(10);
    check(sys_rst_req === 1'b1, "R4", "reset sticky", {31'd0, sys_rst_req}, 32'd1);

    // R5 second expiry without reset enable
    do_reset();
    cyc(1'b1, 3'd0, 32'd3);
    cyc(1'b1, 3'd2, 32'd1);
    idle(9);
    check(irq === 1'b1 && sys_rst_req === 1'b0, "R5", "irq only", {30'd0, irq, sys_rst_req}, 32'd2);
    rd(3'd1, "R5", 32'd2);

    // R6 clear reloads and drops irq
    cyc(1'b1, 3'd3, 32'hDEAD_BEEF);
    check(irq === 1'b0, "R6", "irq cleared", {31'd0, irq}, 32'd0);
    rd(3'd1, "R6", 32'd3);
    // R8 run cannot be cleared
    cyc(1'b1, 3'd2, 32'd0);
    rd(3'd2, "R8", 32'd1);

    // R7 load while counting
    cyc(1'b1, 3'd0, 32'd40);
    idle(2);
    rd(3'd1, "R7", 32'd38);

    // R9/R10 lock
    cyc(1'b1, 3'd6, 32'h0);
    rd(3'd6, "R9", 32'd1);
    cyc(1'b1, 3'd0, 32'd7);
    rd(3'd0, "R10", 32'd40);
    cyc(1'b1, 3'd2, 32'd2);
    rd(3'd2, "R10", 32'd1);
    cyc(1'b1, 3'd6, KEY);
    rd(3'd6, "R9", 32'd0);
    cyc(1'b1, 3'd0, 32'd7);
    rd(3'd0, "R9", 32'd7);

    // R12 read-only writes ignored
    cyc(1'b1, 3'd1, 32'd999);
    rd(3'd1, "R12", 32'd6);
    cyc(1'b1, 3'd7, 32'hFFFF_FFFF);
    rd(3'd7, "R12", 32'd0);

    // random mix against the model
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      int r = int'($urandom % 100);
      logic [2:0] a = 3'($urandom);
      if (i % 700 == 699) do_reset();
      else if (r < 55) cyc(1'b0, a, 32'd0);
      else if (r < 65) cyc(1'b1, 3'd0, $urandom % 24);
      else if (r < 72) cyc(1'b1, 3'd3, $urandom);
      else if (r < 80) cyc(1'b1, 3'd2, {30'd0, 2'($urandom)} | 32'd1);
      else if (r < 84) cyc(1'b1, 3'd6, ($urandom % 2) ? KEY : $urandom);
      else if (r < 88) cyc(1'b1, ($urandom % 2) ? 3'd4 : 3'd5, $urandom);
      else cyc(1'b0, 3'd1, 32'd0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule